// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is an eight-pin general-purpose I/O port with four byte-wide registers that a processor reaches over a simple select/write bus. Software sets the level of every output pin, chooses its direction, picks open-drain or push-pull drive and turns pull-ups on. Drive type and pull-up are set per group of four pins. The block turns these settings into per-pin pad controls: the output level, the output enable, the pull-up enable and the open-drain select. Pad inputs go through a two-flop synchronizer. A read of the data register returns the synchronized pad level for input pins and the output latch for output pins.

Any rising or falling edge on an input pin whose interrupt-enable bit is set moves a small event state machine from `EV_IDLE` to `EV_PENDING`. It stays in `EV_PENDING` until the clear input is pulsed. The named transitions are:
- `EV_IDLE` to `EV_PENDING` on `edge_seen`.
- `EV_PENDING` to `EV_IDLE` on `clear_taken`, which is a clear with no edge in the same cycle.
- `EV_PENDING` holds otherwise, and holds on `edge_beats_clear`, where an edge and a clear arrive in the same cycle.

While the event is pending, two separate global enables gate it onto a halt-release request and an interrupt request.

Top module: `gpio_port`

## Requirements
- R1: The register at offset 1 (direction), offset 2 (mode) and offset 3 (interrupt enable) reads back the last value written to it. Mode bits 2, 3, 6 and 7 always read 0.
- R2: After reset every register reads 0. All pad output enables, pull-ups and open-drain selects are 0, and the event flag is 0.
- R3: A read at offset 0 returns the data latch for pins whose direction bit is 1 (output). For pins whose direction bit is 0 (input), it returns the pad level two clock edges after that level was applied.
- R4: For a push-pull pin (its group's open-drain bit is 0), pad_oe equals the direction bit and pad_out equals the latch bit.
- R5: Mode bit 1 selects open-drain for pins 0–3 and mode bit 5 selects it for pins 4–7; pad_od shows this setting per pin. An open-drain output pin enables its driver only when its latch bit is 0, and pad_out is always 0 for it.
- R6: Mode bit 0 enables the pull-ups for pins 0–3 and mode bit 4 enables them for pins 4–7. A pin with direction 1 never has its pull-up enabled.
- R7: A rising or a falling pad edge on an input pin with its interrupt-enable bit set raises evt_flag on the third rising clock edge after the pad change, and not before.
- R8: An edge on a pin whose interrupt-enable bit is 0, or whose direction bit is 1, leaves evt_flag at 0.
- R9: evt_flag stays set until evt_clr is 1 at a clock edge. When an edge is detected in the same cycle as the clear, the flag stays set.
- R10: halt_release_req is evt_flag AND halt_rel_en, and irq_req is evt_flag AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset (0 data, 1 direction, 2 mode, 3 interrupt enable) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Level driven to each pad |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_pullup | output | 8 | Per-pin pull-up enable |
| pad_od | output | 8 | Per-pin open-drain select |
| halt_rel_en | input | 1 | Global halt-release enable |
| irq_en | input | 1 | Global interrupt enable |
| evt_clr | input | 1 | Clears the port event flag |
| evt_flag | output | 1 | Port event pending |
| halt_release_req | output | 1 | Halt-release request |
| irq_req | output | 1 | Interrupt request |

## Verification
The data path is swept over all 256 direction values, each with a latch pattern and a pad pattern that differ from it. Any pin taking its read value or output enable from the wrong source therefore shows up. Every combination of the four meaningful mode bits is crossed with direction patterns that split the two nibbles, which separates per-group decoding from per-pin decoding and shows whether pull-ups are forced off on output pins. The event state machine is driven with rising edges and falling edges, with masked pins and with output pins. One edge is timed to land on the same cycle as a clear, which separates set-priority from clear-priority.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W    = 8;
    localparam int GROUP_W   = 4;
    localparam int N_GROUPS  = PORT_W / GROUP_W;
    localparam int ADDR_W    = 2;

    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_MODE = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 2'd3;

    // within each group's nibble of the mode register
    localparam int PULL_BIT = 0;
    localparam int OD_BIT   = 1;

    typedef enum logic {
        EV_IDLE,
        EV_PENDING
    } evt_state_t;

    function automatic logic [PORT_W-1:0] mode_mask();
        logic [PORT_W-1:0] m;
        m = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            m[g*GROUP_W + PULL_BIT] = 1'b1;
            m[g*GROUP_W + OD_BIT]   = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic [PORT_W-1:0] sync_in,
    output logic [PORT_W-1:0] bus_rdata,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] mode_q,
    output logic [PORT_W-1:0] ien_q
);

    localparam logic [PORT_W-1:0] MODE_MASK = mode_mask();

    logic wr_en;
    assign wr_en = bus_sel && bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            mode_q  <= '0;
            ien_q   <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                OFS_DATA: latch_q <= bus_wdata;
                OFS_DIR:  dir_q   <= bus_wdata;
                OFS_MODE: mode_q  <= bus_wdata & MODE_MASK;
                OFS_IEN:  ien_q   <= bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = (dir_q & latch_q) | (~dir_q & sync_in);
            OFS_DIR:  bus_rdata = dir_q;
            OFS_MODE: bus_rdata = mode_q;
            OFS_IEN:  bus_rdata = ien_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_port_pkg::*;
(
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] mode_q,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pullup,
    output logic [PORT_W-1:0] pad_od
);

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic grp_pull;
        logic grp_od;
        assign grp_pull = mode_q[g*GROUP_W + PULL_BIT];
        assign grp_od   = mode_q[g*GROUP_W + OD_BIT];

        for (genvar b = 0; b < GROUP_W; b++) begin : g_pin
            localparam int P = g*GROUP_W + b;
            always_comb begin
                pad_od[P]     = grp_od;
                pad_pullup[P] = grp_pull && !dir_q[P];
                if (grp_od) begin
                    pad_out[P] = 1'b0;
                    pad_oe[P]  = dir_q[P] && !latch_q[P];
                end else begin
                    pad_out[P] = latch_q[P];
                    pad_oe[P]  = dir_q[P];
                end
            end
        end
    end

endmodule

// File: rtl/gpio_edge_evt.sv
module gpio_edge_evt
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pad_in,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] ien_q,
    input  logic              evt_clr,
    output logic [PORT_W-1:0] sync_in,
    output logic              evt_flag
);

    logic [PORT_W-1:0] meta_q;
    logic [PORT_W-1:0] sync_q;
    logic [PORT_W-1:0] prev_q;
    logic              edge_seen;
    evt_state_t        state_q;
    evt_state_t        state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_in   = sync_q;
    assign edge_seen = |((sync_q ^ prev_q) & ien_q & ~dir_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:    if (edge_seen)                state_d = EV_PENDING;
            EV_PENDING: if (evt_clr && !edge_seen)    state_d = EV_IDLE;
            default:                                  state_d = EV_IDLE;
        endcase
    end

    always_comb begin
        evt_flag = (state_q == EV_PENDING);
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pullup,
    output logic [PORT_W-1:0] pad_od,
    input  logic              halt_rel_en,
    input  logic              irq_en,
    input  logic              evt_clr,
    output logic              evt_flag,
    output logic              halt_release_req,
    output logic              irq_req
);

    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] mode_q;
    logic [PORT_W-1:0] ien_q;
    logic [PORT_W-1:0] sync_in;

    gpio_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sync_in   (sync_in),
        .bus_rdata (bus_rdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .mode_q    (mode_q),
        .ien_q     (ien_q)
    );

    gpio_pad_ctl u_pads (
        .latch_q    (latch_q),
        .dir_q      (dir_q),
        .mode_q     (mode_q),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_pullup (pad_pullup),
        .pad_od     (pad_od)
    );

    gpio_edge_evt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .dir_q    (dir_q),
        .ien_q    (ien_q),
        .evt_clr  (evt_clr),
        .sync_in  (sync_in),
        .evt_flag (evt_flag)
    );

    always_comb begin
        halt_release_req = evt_flag && halt_rel_en;
        irq_req          = evt_flag && irq_en;
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] pad_pullup,
    input logic [PORT_W-1:0] pad_od,
    input logic              halt_rel_en,
    input logic              irq_en,
    input logic              evt_clr,
    input logic              evt_flag,
    input logic              halt_release_req,
    input logic              irq_req
);

    localparam logic [PORT_W-1:0] MODE_MASK = mode_mask();

    // R1
    mode_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_MODE) |-> ((bus_rdata & ~MODE_MASK) == '0));

    // R6
    pull_off_when_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pullup & pad_oe) == '0));

    // R5
    od_drives_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_od & pad_oe & pad_out) == '0));

    // R9
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !evt_clr) |=> evt_flag);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (evt_flag && irq_en));

    // R10
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_release_req |-> (evt_flag && halt_rel_en));

endmodule

bind gpio_port gpio_port_chk u_chk (.*);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'd0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] pad_pullup;
    logic [7:0] pad_od;
    logic       halt_rel_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       evt_clr = 1'b0;
    logic       evt_flag;
    logic       halt_release_req;
    logic       irq_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pullup(pad_pullup), .pad_od(pad_od),
        .halt_rel_en(halt_rel_en), .irq_en(irq_en), .evt_clr(evt_clr),
        .evt_flag(evt_flag), .halt_release_req(halt_release_req), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic after_edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] mode_of(input logic [3:0] m);
        return {2'b00, m[3], m[2], 2'b00, m[1], m[0]};
    endfunction

    initial begin : main
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            check("R2 reg reset", r, 8'h00);
        end
        check("R2 oe reset", pad_oe, 8'h00);
        check("R2 pullup reset", pad_pullup, 8'h00);
        check("R2 od reset", pad_od, 8'h00);
        check("R2 flag reset", {7'd0, evt_flag}, 8'h00);

        // R1 readback
        wr(2'd3, 8'hA5); rd(2'd3, r); check("R1 ien readback", r, 8'hA5);
        wr(2'd2, 8'hFF); rd(2'd2, r); check("R1 mode unused bits", r, 8'h33);
        wr(2'd2, 8'h00); wr(2'd3, 8'h00);

        // R3 R4 direction sweep, push-pull
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dir, lat, pad;
            dir = d[7:0]; lat = dir ^ 8'h5A; pad = ~dir ^ 8'h0F;
            @(negedge clk); pad_in = pad;
            wr(2'd1, dir);
            wr(2'd0, lat);
            rd(2'd1, r);
            check("R1 dir readback", r, dir);
            rd(2'd0, r);
            check("R3 data read", r, (dir & lat) | (~dir & pad));
            check("R4 pp oe", pad_oe, dir);
            check("R4 pp out", pad_out, lat);
        end

        // R5 R6 mode sweep
        for (int m = 0; m < 16; m++) begin
            logic [7:0] mv;
            mv = mode_of(m[3:0]);
            wr(2'd2, mv | 8'hCC);
            rd(2'd2, r);
            check("R1 mode readback", r, mv);
            for (int k = 0; k < 5; k++) begin
                logic [7:0] dir, lat, e_oe, e_out, e_pu, e_od;
                dir = (k == 0) ? 8'h00 : (k == 1) ? 8'h0F : (k == 2) ? 8'hF0 :
                      (k == 3) ? 8'hA5 : 8'hFF;
                lat = 8'h3C;
                wr(2'd1, dir);
                wr(2'd0, lat);
                #1;
                for (int i = 0; i < 8; i++) begin
                    logic od, pu;
                    od = (i < 4) ? mv[1] : mv[5];
                    pu = (i < 4) ? mv[0] : mv[4];
                    e_od[i]  = od;
                    e_pu[i]  = pu & ~dir[i];
                    e_out[i] = od ? 1'b0 : lat[i];
                    e_oe[i]  = dir[i] & (od ? ~lat[i] : 1'b1);
                end
                check("R5 od select", pad_od, e_od);
                check("R5 oe", pad_oe, e_oe);
                check("R5 out", pad_out, e_out);
                check("R6 pullup", pad_pullup, e_pu);
            end
        end

        // R8 masked pin and output pin
        wr(2'd2, 8'h00); wr(2'd1, 8'h08); wr(2'd3, 8'h08);
        @(negedge clk); pad_in = 8'h00;
        after_edges(4);
        wr(2'd3, 8'h09); // pins 0 and 3 enabled, pin 3 is output
        @(negedge clk); pad_in = 8'h08;
        after_edges(4);
        check("R8 output pin edge", {7'd0, evt_flag}, 8'h00);
        @(negedge clk); pad_in = 8'h0A; // pin1 not enabled
        after_edges(4);
        check("R8 masked pin edge", {7'd0, evt_flag}, 8'h00);

        // R7 rising edge timing on pin 0
        @(negedge clk); pad_in = 8'h0B;
        after_edges(2);
        check("R7 not before third edge", {7'd0, evt_flag}, 8'h00);
        after_edges(1);
        check("R7 rise sets flag", {7'd0, evt_flag}, 8'h01);

        // R10 gating
        @(negedge clk); halt_rel_en = 1'b1; irq_en = 1'b0; #1;
        check("R10 halt req", {6'd0, halt_release_req, irq_req}, 8'h02);
        @(negedge clk); halt_rel_en = 1'b0; irq_en = 1'b1; #1;
        check("R10 irq req", {6'd0, halt_release_req, irq_req}, 8'h01);

        // R9 hold then clear
        after_edges(5);
        check("R9 flag holds", {7'd0, evt_flag}, 8'h01);
        @(negedge clk); evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0; #1;
        check("R9 clear", {7'd0, evt_flag}, 8'h00);
        @(negedge clk); halt_rel_en = 1'b1; #1;
        check("R10 no req without flag", {6'd0, halt_release_req, irq_req}, 8'h00);

        // R7 falling edge
        @(negedge clk); pad_in = 8'h0A;
        after_edges(3);
        check("R7 fall sets flag", {7'd0, evt_flag}, 8'h01);

        // R9 set wins over same-cycle clear
        @(negedge clk); pad_in = 8'h0B;
        after_edges(2);
        @(negedge clk); evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0; #1;
        check("R9 set beats clear", {7'd0, evt_flag}, 8'h01);
        @(negedge clk); evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0; #1;
        check("R9 clear after", {7'd0, evt_flag}, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule